// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block is the hardware loop unit beside the instruction fetch stage of a small DSP-style core. It holds a loop-start address register, a loop-end address register and a 12-bit repeat counter. Three decoded commands load them: one loads the start register, one loads the end register, and a set-count command comes in two forms. The immediate form takes an 8-bit value and the register form takes the low 12 bits of a general register. Each address load computes the command's program counter plus twice a signed displacement. Instructions are 16 bits wide, so addresses move in steps of 2.

The block classifies the loop size from the difference between the two address registers at the moment a set-count command is issued. A difference of 4 means a 1-instruction loop, 2 means 2 instructions, 0 means 3 instructions, and any other value means 4 or more. Let A be the address of the instruction just before the loop body. The loop body starts at A+2. For the three short loop sizes the start register holds A+8, A+6 or A+4 and the end register holds A+4. For longer loops the start register holds the first loop instruction and the end register holds the last loop instruction minus 2. While the counter is above 1, a fetch address equal to the last loop instruction raises a redirect to the first loop instruction in the same cycle, and the counter decrements at the next clock edge.

The control is a two-state machine. ST_IDLE means no loop is active and the counter is 0 or 1. ST_LOOP means the counter is 2 or more. The transitions are:
- ARM: ST_IDLE to ST_LOOP on a set-count command whose value exceeds 1.
- RELOAD: ST_LOOP to ST_LOOP on a set-count command whose value exceeds 1.
- CANCEL: either state to ST_IDLE on a set-count command whose value is 0 or 1.
- WRAP: ST_LOOP to ST_LOOP on a redirect with the counter above 2.
- EXIT: ST_LOOP to ST_IDLE on a redirect with the counter equal to 2.
- RESET: any state to ST_IDLE on synchronous reset.

Top module: `zrl_ctrl`

## Requirements
- R1: When `ld_start` is high at a clock edge, `start_addr` becomes `cmd_pc + 2*sext(cmd_disp)` after that edge.
- R2: When `ld_end` is high at a clock edge, `end_addr` becomes `cmd_pc + 2*sext(cmd_disp)` after that edge.
- R3: When `set_cnt_imm` is high at a clock edge, `rpt_count` becomes the zero-extended `imm_cnt`, which lies in the range 0 to 255.
- R4: When `set_cnt_reg` is high at a clock edge, `rpt_count` becomes `gpr_val[11:0]`, which lies in the range 0 to 4095.
- R5: `rpt_flag` is 2'b00 whenever `rpt_count` is 0 or 1. Otherwise it holds the size code latched at the last set-count command, classified from start minus end: 4 gives 2'b01, 2 gives 2'b10, and 0 or any other value gives 2'b11.
- R6: The loop's last fetch address is end-2, end, end+2 or end+2, and its first address is start-6, start-4, start-2 or start, for sizes 1, 2, 3 and 4 or more respectively.
- R7: While `rpt_count` > 1, `redirect` is high in the same cycle that `fetch_pc` equals the last fetch address, with `redirect_pc` equal to the first address. At all other times `redirect` is low.
- R8: Each redirect decrements `rpt_count` by one at the next edge. Once the count reaches 1, no further redirect occurs and `rpt_flag` is 2'b00.
- R9: A set-count command issued during an active loop replaces the count and takes priority over a redirect in the same cycle.
- R10: Synchronous reset clears `start_addr`, `end_addr`, `rpt_count` and `rpt_flag`, and leaves `redirect` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_pc | input | AW (32) | Base program counter of the current command |
| cmd_disp | input | DW (8) | Signed displacement in instruction units |
| ld_start | input | 1 | Load the loop-start register |
| ld_end | input | 1 | Load the loop-end register |
| set_cnt_imm | input | 1 | Set the count from the immediate |
| imm_cnt | input | IW (8) | Immediate count value |
| set_cnt_reg | input | 1 | Set the count from the register |
| gpr_val | input | RW (32) | Register operand; the low 12 bits are used |
| fetch_pc | input | AW (32) | Current fetch address |
| redirect | output | 1 | Redirect fetch to the loop start |
| redirect_pc | output | AW (32) | Redirect target |
| rpt_flag | output | 2 | Loop-size status |
| rpt_count | output | CW (12) | Repeat counter |
| start_addr | output | AW (32) | Loop-start register |
| end_addr | output | AW (32) | Loop-end register |

## Verification
The assertions assume the decoder issues at most one of the four commands in any cycle. The stimulus keeps to that rule by raising a single strobe per task and clearing it on the next falling edge. They also assume that a set-count command uses the address registers as loaded before that command. The bench therefore always loads the start and end registers in earlier cycles than the count. Fetch addresses are held steady across edges, so a redirect can be seen on consecutive cycles until the counter runs out.

// File: rtl/zrl_pkg.sv
package zrl_pkg;

    typedef enum logic [1:0] {
        SZ_ONE   = 2'd0,
        SZ_TWO   = 2'd1,
        SZ_THREE = 2'd2,
        SZ_WIDE  = 2'd3
    } loop_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOOP = 1'b1
    } loop_state_e;

    function automatic logic [1:0] size_to_flag(input loop_size_e sz);
        case (sz)
            SZ_ONE:  size_to_flag = 2'b01;
            SZ_TWO:  size_to_flag = 2'b10;
            default: size_to_flag = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/zrl_target_gen.sv
module zrl_target_gen #(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base_pc,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] target
);
    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
        target   = base_pc + (disp_ext << 1);
    end
endmodule

// File: rtl/zrl_size_classify.sv
module zrl_size_classify #(
    parameter int AW = 32
) (
    input  logic [AW-1:0]       rs,
    input  logic [AW-1:0]       re,
    output zrl_pkg::loop_size_e size
);
    import zrl_pkg::*;
    logic [AW-1:0] gap;

    always_comb begin
        gap = rs - re;
        if (gap == AW'(4))      size = SZ_ONE;
        else if (gap == AW'(2)) size = SZ_TWO;
        else if (gap == '0)     size = SZ_THREE;
        else                    size = SZ_WIDE;
    end
endmodule

// File: rtl/zrl_bounds.sv
module zrl_bounds #(
    parameter int AW = 32
) (
    input  logic [AW-1:0]       rs,
    input  logic [AW-1:0]       re,
    input  zrl_pkg::loop_size_e size,
    output logic [AW-1:0]       first_pc,
    output logic [AW-1:0]       last_pc
);
    import zrl_pkg::*;

    always_comb begin
        unique case (size)
            SZ_ONE: begin
                first_pc = rs - AW'(6);
                last_pc  = re - AW'(2);
            end
            SZ_TWO: begin
                first_pc = rs - AW'(4);
                last_pc  = re;
            end
            SZ_THREE: begin
                first_pc = rs - AW'(2);
                last_pc  = re + AW'(2);
            end
            default: begin
                first_pc = rs;
                last_pc  = re + AW'(2);
            end
        endcase
    end
endmodule

// File: rtl/zrl_ctrl.sv
module zrl_ctrl #(
    parameter int AW = 32,
    parameter int DW = 8,
    parameter int IW = 8,
    parameter int RW = 32,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cmd_pc,
    input  logic [DW-1:0] cmd_disp,
    input  logic          ld_start,
    input  logic          ld_end,
    input  logic          set_cnt_imm,
    input  logic [IW-1:0] imm_cnt,
    input  logic          set_cnt_reg,
    input  logic [RW-1:0] gpr_val,
    input  logic [AW-1:0] fetch_pc,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc,
    output logic [1:0]    rpt_flag,
    output logic [CW-1:0] rpt_count,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr
);
    import zrl_pkg::*;

    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [CW-1:0] CNT_TWO = CW'(2);

    loop_state_e   state_q, state_d;
    loop_size_e    size_live, size_q;
    logic [AW-1:0] rs_q, re_q, target, first_pc, last_pc;
    logic [CW-1:0] cnt_q, new_cnt;
    logic          set_any, hit;

    zrl_target_gen #(.AW(AW), .DW(DW)) u_target (
        .base_pc(cmd_pc), .disp(cmd_disp), .target(target)
    );

    zrl_size_classify #(.AW(AW)) u_classify (
        .rs(rs_q), .re(re_q), .size(size_live)
    );

    zrl_bounds #(.AW(AW)) u_bounds (
        .rs(rs_q), .re(re_q), .size(size_q),
        .first_pc(first_pc), .last_pc(last_pc)
    );

    always_comb begin
        set_any = set_cnt_imm | set_cnt_reg;
        if (set_cnt_reg) new_cnt = gpr_val[CW-1:0];
        else             new_cnt = {{(CW-IW){1'b0}}, imm_cnt};
        hit = (state_q == ST_LOOP) && (fetch_pc == last_pc);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (set_any && new_cnt > CNT_ONE) state_d = ST_LOOP;   // ARM
            end
            ST_LOOP: begin
                if (set_any) begin
                    if (new_cnt <= CNT_ONE) state_d = ST_IDLE;          // CANCEL
                end else if (hit && cnt_q == CNT_TWO) begin
                    state_d = ST_IDLE;                                  // EXIT
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q   <= '0;
            re_q   <= '0;
            cnt_q  <= '0;
            size_q <= SZ_ONE;
        end else begin
            if (ld_start) rs_q <= target;
            if (ld_end)   re_q <= target;
            if (set_any) begin
                cnt_q  <= new_cnt;
                size_q <= size_live;
            end else if (hit) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        redirect    = hit;
        redirect_pc = first_pc;
        rpt_flag    = (state_q == ST_LOOP) ? size_to_flag(size_q) : 2'b00;
        rpt_count   = cnt_q;
        start_addr  = rs_q;
        end_addr    = re_q;
    end

    // assumption on the decoder: one command per cycle
    p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_start, ld_end, set_cnt_imm, set_cnt_reg}));

    p_imm_load_r3: assert property (@(posedge clk) disable iff (rst)
        set_cnt_imm |=> rpt_count == {{(CW-IW){1'b0}}, $past(imm_cnt)});

    p_reg_load_r4: assert property (@(posedge clk) disable iff (rst)
        set_cnt_reg |=> rpt_count == $past(gpr_val[CW-1:0]));

    p_flag_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (rpt_count <= CNT_ONE) |-> rpt_flag == 2'b00);

    p_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        (rpt_count <= CNT_ONE) |-> !redirect);

    p_decrement_r8: assert property (@(posedge clk) disable iff (rst)
        (redirect && !set_cnt_imm && !set_cnt_reg) |=> rpt_count == $past(rpt_count) - CNT_ONE);

    p_state_count_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOP) == (cnt_q > CNT_ONE));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (rpt_count == '0 && start_addr == '0 && end_addr == '0));
endmodule

// File: tb/tb_zrl_ctrl.sv
module tb_zrl_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] cmd_pc = '0;
    logic [7:0]  cmd_disp = '0;
    logic        ld_start = 0, ld_end = 0, set_cnt_imm = 0, set_cnt_reg = 0;
    logic [7:0]  imm_cnt = '0;
    logic [31:0] gpr_val = '0;
    logic [31:0] fetch_pc = '0;
    logic        redirect;
    logic [31:0] redirect_pc, start_addr, end_addr;
    logic [1:0]  rpt_flag;
    logic [11:0] rpt_count;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    zrl_ctrl dut (
        .clk(clk), .rst(rst), .cmd_pc(cmd_pc), .cmd_disp(cmd_disp),
        .ld_start(ld_start), .ld_end(ld_end), .set_cnt_imm(set_cnt_imm),
        .imm_cnt(imm_cnt), .set_cnt_reg(set_cnt_reg), .gpr_val(gpr_val),
        .fetch_pc(fetch_pc), .redirect(redirect), .redirect_pc(redirect_pc),
        .rpt_flag(rpt_flag), .rpt_count(rpt_count),
        .start_addr(start_addr), .end_addr(end_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; #1;
    endtask

    task automatic load_start(input logic [31:0] pc, input logic [7:0] d);
        @(negedge clk); cmd_pc = pc; cmd_disp = d; ld_start = 1;
        @(negedge clk); ld_start = 0; #1;
    endtask

    task automatic load_end(input logic [31:0] pc, input logic [7:0] d);
        @(negedge clk); cmd_pc = pc; cmd_disp = d; ld_end = 1;
        @(negedge clk); ld_end = 0; #1;
    endtask

    task automatic set_imm(input logic [7:0] v);
        @(negedge clk); imm_cnt = v; set_cnt_imm = 1;
        @(negedge clk); set_cnt_imm = 0; #1;
    endtask

    task automatic set_reg(input logic [31:0] v);
        @(negedge clk); gpr_val = v; set_cnt_reg = 1;
        @(negedge clk); set_cnt_reg = 0; #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 count", rpt_count, 0);
        chk("R10 flag", rpt_flag, 0);
        chk("R10 start", start_addr, 0);
        chk("R10 end", end_addr, 0);
        chk("R10 redirect", redirect, 0);
    endtask

    task automatic t_address_loads();
        load_start(32'h1000, 8'd4);
        chk("R1 positive disp", start_addr, 32'h1008);
        load_start(32'h1010, 8'hFE);
        chk("R1 negative disp", start_addr, 32'h100C);
        load_end(32'h1000, 8'd2);
        chk("R2 end load", end_addr, 32'h1004);
        chk("R2 start untouched", start_addr, 32'h100C);
    endtask

    task automatic t_one_instr();
        load_start(32'h1000, 8'd4);
        load_end(32'h1000, 8'd2);
        fetch_pc = 32'h1004;
        set_imm(8'd3);
        chk("R3 imm count", rpt_count, 3);
        chk("R5 size1 flag", rpt_flag, 2'b01);
        chk("R7 no hit off-loop", redirect, 0);
        fetch_pc = 32'h1002; #1;
        chk("R6 R7 size1 redirect", redirect, 1);
        chk("R6 size1 target", redirect_pc, 32'h1002);
        step();
        chk("R8 decrement", rpt_count, 2);
        chk("R7 still redirect", redirect, 1);
        step();
        chk("R8 final count", rpt_count, 1);
        chk("R8 no redirect at 1", redirect, 0);
        chk("R8 flag clears", rpt_flag, 0);
        step();
        chk("R8 holds at 1", rpt_count, 1);
        fetch_pc = 32'h0;
    endtask

    task automatic t_two_instr();
        load_start(32'h1000, 8'd3);
        load_end(32'h1000, 8'd2);
        set_reg(32'hABC002);
        chk("R4 reg low bits", rpt_count, 2);
        chk("R5 size2 flag", rpt_flag, 2'b10);
        fetch_pc = 32'h1002; #1;
        chk("R7 first instr no hit", redirect, 0);
        fetch_pc = 32'h1004; #1;
        chk("R6 size2 redirect", redirect, 1);
        chk("R6 size2 target", redirect_pc, 32'h1002);
        step();
        chk("R8 size2 count", rpt_count, 1);
        chk("R8 size2 no redirect", redirect, 0);
        fetch_pc = 32'h0;
    endtask

    task automatic t_three_instr();
        load_start(32'h1000, 8'd2);
        load_end(32'h1000, 8'd2);
        set_imm(8'd5);
        chk("R5 size3 flag", rpt_flag, 2'b11);
        fetch_pc = 32'h1006; #1;
        chk("R6 size3 redirect", redirect, 1);
        chk("R6 size3 target", redirect_pc, 32'h1002);
        step();
        chk("R8 size3 count", rpt_count, 4);
        fetch_pc = 32'h0;
    endtask

    task automatic t_wide_and_reload();
        load_start(32'h2000, 8'd0);
        load_end(32'h2000, 8'd8);
        set_reg(32'h1FFF);
        chk("R4 max count", rpt_count, 12'hFFF);
        chk("R5 wide flag", rpt_flag, 2'b11);
        fetch_pc = 32'h2010; #1;
        chk("R6 wide end-reg no hit", redirect, 0);
        fetch_pc = 32'h2012; #1;
        chk("R6 wide redirect", redirect, 1);
        chk("R6 wide target", redirect_pc, 32'h2000);
        step();
        chk("R8 wide count", rpt_count, 12'hFFE);
        set_imm(8'd2);
        chk("R9 reload beats redirect", rpt_count, 2);
        set_imm(8'd255);
        chk("R3 imm max", rpt_count, 255);
        set_imm(8'd1);
        chk("R9 cancel count", rpt_count, 1);
        chk("R9 cancel flag", rpt_flag, 0);
        chk("R9 cancel redirect", redirect, 0);
        set_imm(8'd0);
        chk("R7 zero count no redirect", redirect, 0);
        set_imm(8'd9);
        do_reset();
        chk("R10 mid-loop count", rpt_count, 0);
        chk("R10 mid-loop flag", rpt_flag, 0);
        chk("R10 mid-loop redirect", redirect, 0);
        fetch_pc = 32'h0;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_address_loads();
        t_one_instr();
        t_two_instr();
        t_three_instr();
        t_wide_and_reload();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule